// File: doc/BRIEF.md
# Two-Wire Serial Programming Command Sequencer

This block is the host side of a two-wire in-circuit programming link to a small microcontroller. It generates the serial clock and drives or releases the bidirectional data line. It also controls the enable of the programming-voltage switch. A local requester hands it one operation at a time over a valid/ready handshake: enter programming mode, leave it, send a CPU instruction, read back a table byte, start a timed programming pulse, or run the whole bulk-erase sequence.

Every serial frame carries a 4-bit command and then a 16-bit payload, each least significant bit first. The data line changes with the rising clock edge and holds steady while the clock is high, so the target can sample it on the falling edge. A read frame turns the line around for its last eight clocks and brings back one byte. A programming frame stretches its fourth clock into a long high and low hold. All line timings are parameter counts of the system clock: the clock half period, the entry and exit waits, the programming high and low holds, and the erase hold.

Top module: `serial_prog_seq`

## Requirements
- R1: After reset the clock line is low, the data line is driven low (`pgdOe`=1, `pgdOut`=0), `vppEn` is 0, `busy` and `done` are 0 and `reqReady` is 1.
- R2: Opcode 0 (enter) raises `vppEn` with clock and data low. `vppEn` then stays high for exactly ENTRY_CYC busy cycles with no clock pulse before `done`.
- R3: Opcode 1 (core instruction) sends 20 clock pulses. The data seen at falling edge n is bit n of {payload, command}: the command first, then the payload, each LSb first. Each clock is high for HALF_DIV cycles, and the low time between two pulses of a frame is HALF_DIV cycles.
- R4: `pgdOut` and `pgdOe` never change while the clock stays high. They change only on a rising clock edge or while the clock is low.
- R5: Opcode 2 (table read) drives the command on clocks 0 to 3 and drives the line low on clocks 4 to 11, whatever the payload. It releases the line (`pgdOe`=0) on clocks 12 to 19 and samples `pgdIn` in the last system cycle before each of those falling edges. The eight samples, first one as bit 0, appear on `rdData` when `done` is high.
- R6: Opcode 3 (programming start) sends a normal 20-bit frame, except that clock 3 is high for HOLD_HI_CYC cycles and is followed by a low time of HOLD_LO_CYC cycles before clock 4.
- R7: Opcode 5 (bulk erase) sends twelve frames as {command, payload}: (0,0E3C) (0,6EF8) (0,0E00) (0,6EF7) (0,0E05) (0,6EF6) (C,0F0F) (0,0E04) (0,6EF6) (C,8F8F) (0,0000) (0,0000). In the last frame the data line stays low and the clock stays low for ERASE_CYC+HOLD_LO_CYC cycles between clock 3 and clock 4.
- R8: Opcode 4 (exit) keeps the clock and data low for EXIT_CYC busy cycles with `vppEn` still high, then drops `vppEn` in the same cycle that `done` rises.
- R9: A request is taken when `reqValid` and `reqReady` are both high, and `reqReady` is low while `busy` is high. `busy` stays high from acceptance through the whole frame, including any hold. `done` is a single-cycle pulse that rises in the cycle `busy` falls.
- R10: `vppEn` changes only through enter and exit. It stays high across core, read, programming and erase operations, and the clock toggles only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer can accept a request |
| reqOp | input | 3 | Operation: 0 enter, 1 core, 2 read, 3 program, 4 exit, 5 erase |
| reqCmd | input | 4 | 4-bit serial command for frame operations |
| reqPayload | input | 16 | 16-bit payload for frame operations |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte captured by the last read frame |
| pgc | output | 1 | Serial clock line |
| pgdOut | output | 1 | Data value driven on the data line |
| pgdOe | output | 1 | Data line drive enable (0 = released) |
| pgdIn | input | 1 | Data line value seen from the target |
| vppEn | output | 1 | Programming-voltage switch enable |

## Verification
Several properties are checked on every cycle. The data line and its enable hold steady through each clock-high interval. The line is released and the clock toggles only while busy. The programming-voltage enable rises only on an accepted enter and falls only with a completion pulse, and that pulse lasts one cycle and ends a busy interval. Whether the bit order, the exact high and low widths, the stretched programming clock, the erase hold and the returned byte are right can only be shown by the bench's scenarios. There a target model reconstructs every frame from the line edges and drives back all 256 byte values.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  localparam int CMD_W   = 4;
  localparam int PAY_W   = 16;
  localparam int FRAME_W = CMD_W + PAY_W;
  localparam int RD_W    = 8;
  localparam int ERASE_STEPS = 12;
  localparam int IDX_W   = $clog2(FRAME_W + 1);
  localparam int STEP_W  = $clog2(ERASE_STEPS);

  localparam logic [2:0] OP_ENTER = 3'd0;
  localparam logic [2:0] OP_CORE  = 3'd1;
  localparam logic [2:0] OP_READ  = 3'd2;
  localparam logic [2:0] OP_PROG  = 3'd3;
  localparam logic [2:0] OP_EXIT  = 3'd4;
  localparam logic [2:0] OP_ERASE = 3'd5;

  typedef enum logic [1:0] {DRV_BIT, DRV_ZERO, DRV_OFF} drv_e;
  typedef enum logic [2:0] {T_DIV, T_HHI, T_HLO, T_ERASE, T_ENTRY, T_EXIT} tsel_e;

  typedef struct packed {
    logic               load;
    logic [FRAME_W-1:0] loadWord;
    logic               rise;
    drv_e               riseMode;
    logic               fall;
    logic               advance;
    logic               sample;
    logic               timerLoad;
    tsel_e              tmrSel;
    logic               forceLow;
    logic               vppSet;
    logic               vppClr;
    logic               finish;
  } ctl_t;

  // Canned bulk-erase frames, returned as {payload, command}
  function automatic logic [FRAME_W-1:0] eraseFrame(input logic [STEP_W-1:0] idx);
    logic [3:0]  c;
    logic [15:0] p;
    c = 4'h0;
    case (idx)
      4'd0:  p = 16'h0E3C;
      4'd1:  p = 16'h6EF8;
      4'd2:  p = 16'h0E00;
      4'd3:  p = 16'h6EF7;
      4'd4:  p = 16'h0E05;
      4'd5:  p = 16'h6EF6;
      4'd6:  begin c = 4'hC; p = 16'h0F0F; end
      4'd7:  p = 16'h0E04;
      4'd8:  p = 16'h6EF6;
      4'd9:  begin c = 4'hC; p = 16'h8F8F; end
      default: p = 16'h0000;
    endcase
    return {p, c};
  endfunction

endpackage

// File: rtl/sprog_dp.sv
module sprog_dp
  import sprog_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int HALF_DIV    = 4,
  parameter int ENTRY_CYC   = 100,
  parameter int EXIT_CYC    = 100,
  parameter int HOLD_HI_CYC = 1000,
  parameter int HOLD_LO_CYC = 50,
  parameter int ERASE_CYC   = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic             pgdIn,
  output logic [IDX_W-1:0] bitIdx,
  output logic             timerZero,
  output logic             pgc,
  output logic             pgdOut,
  output logic             pgdOe,
  output logic             vppEn,
  output logic             done,
  output logic [RD_W-1:0]  rdData
);

  logic [FRAME_W-1:0] shiftReg;
  logic [TMR_W-1:0]   timer;
  logic [TMR_W-1:0]   tmrValue;

  always_comb begin
    case (ctl.tmrSel)
      T_HHI:   tmrValue = TMR_W'(HOLD_HI_CYC);
      T_HLO:   tmrValue = TMR_W'(HOLD_LO_CYC);
      T_ERASE: tmrValue = TMR_W'(ERASE_CYC + HOLD_LO_CYC);
      T_ENTRY: tmrValue = TMR_W'(ENTRY_CYC);
      T_EXIT:  tmrValue = TMR_W'(EXIT_CYC);
      default: tmrValue = TMR_W'(HALF_DIV);
    endcase
  end

  assign timerZero = (timer == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitIdx   <= '0;
      timer    <= '0;
      pgc      <= 1'b0;
      pgdOut   <= 1'b0;
      pgdOe    <= 1'b1;
      vppEn    <= 1'b0;
      done     <= 1'b0;
      rdData   <= '0;
    end else begin
      done <= ctl.finish;
      if (ctl.load) begin
        shiftReg <= ctl.loadWord;
        bitIdx   <= '0;
      end else if (ctl.advance) begin
        shiftReg <= shiftReg >> 1;
        bitIdx   <= bitIdx + IDX_W'(1);
      end
      if (ctl.timerLoad) timer <= tmrValue - TMR_W'(1);
      else if (!timerZero) timer <= timer - TMR_W'(1);
      if (ctl.rise) begin
        pgc <= 1'b1;
        case (ctl.riseMode)
          DRV_BIT:  begin pgdOut <= shiftReg[0]; pgdOe <= 1'b1; end
          DRV_ZERO: begin pgdOut <= 1'b0;        pgdOe <= 1'b1; end
          default:  begin pgdOut <= 1'b0;        pgdOe <= 1'b0; end
        endcase
      end
      if (ctl.fall) pgc <= 1'b0;
      if (ctl.forceLow || ctl.finish) begin
        pgc    <= 1'b0;
        pgdOut <= 1'b0;
        pgdOe  <= 1'b1;
      end
      if (ctl.sample) rdData <= {pgdIn, rdData[RD_W-1:1]};
      if (ctl.vppSet) vppEn <= 1'b1;
      if (ctl.vppClr) vppEn <= 1'b0;
    end
  end

endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl
  import sprog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [CMD_W-1:0] reqCmd,
  input  logic [PAY_W-1:0] reqPayload,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             timerZero,
  output logic             reqReady,
  output logic             busy,
  output ctl_t             ctl
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_HIGH, S_LOW, S_HOLDHI, S_HOLDLO,
    S_ERWAIT, S_WENT, S_WEXIT, S_NULL
  } state_e;

  state_e            state, nextState;
  logic [2:0]        opQ, opNext;
  logic [STEP_W-1:0] step, stepNext;

  logic riseHold, frameEnd, lastStep, eraseHold, readTail;
  logic doRise, doEnd;
  drv_e riseModeNow;

  assign riseHold  = (opQ == OP_PROG) && (bitIdx == IDX_W'(CMD_W - 1));
  assign frameEnd  = (bitIdx == IDX_W'(FRAME_W));
  assign lastStep  = (step == STEP_W'(ERASE_STEPS - 1));
  assign eraseHold = (opQ == OP_ERASE) && lastStep;
  assign readTail  = (opQ == OP_READ) && (bitIdx >= IDX_W'(CMD_W + RD_W));

  always_comb begin
    if (opQ != OP_READ || bitIdx < IDX_W'(CMD_W)) riseModeNow = DRV_BIT;
    else if (!readTail)                          riseModeNow = DRV_ZERO;
    else                                         riseModeNow = DRV_OFF;
  end

  assign reqReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);

  always_comb begin
    ctl       = '0;
    nextState = state;
    opNext    = opQ;
    stepNext  = step;
    doRise    = 1'b0;
    doEnd     = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin
        opNext = reqOp;
        case (reqOp)
          OP_ENTER: begin
            ctl.forceLow  = 1'b1;
            ctl.vppSet    = 1'b1;
            ctl.timerLoad = 1'b1;
            ctl.tmrSel    = T_ENTRY;
            nextState     = S_WENT;
          end
          OP_EXIT: begin
            ctl.forceLow  = 1'b1;
            ctl.timerLoad = 1'b1;
            ctl.tmrSel    = T_EXIT;
            nextState     = S_WEXIT;
          end
          OP_CORE, OP_READ, OP_PROG: begin
            ctl.load     = 1'b1;
            ctl.loadWord = {reqPayload, reqCmd};
            nextState    = S_START;
          end
          OP_ERASE: begin
            stepNext     = '0;
            ctl.load     = 1'b1;
            ctl.loadWord = eraseFrame('0);
            nextState    = S_START;
          end
          default: nextState = S_NULL;
        endcase
      end
      S_START: doRise = 1'b1;
      S_HIGH: if (timerZero) begin
        ctl.fall      = 1'b1;
        ctl.advance   = 1'b1;
        ctl.sample    = readTail;
        ctl.timerLoad = 1'b1;
        if (eraseHold && bitIdx == IDX_W'(CMD_W - 1)) begin
          ctl.forceLow = 1'b1;
          ctl.tmrSel   = T_ERASE;
          nextState    = S_ERWAIT;
        end else begin
          ctl.tmrSel = T_DIV;
          nextState  = S_LOW;
        end
      end
      S_HOLDHI: if (timerZero) begin
        ctl.fall      = 1'b1;
        ctl.advance   = 1'b1;
        ctl.timerLoad = 1'b1;
        ctl.tmrSel    = T_HLO;
        nextState     = S_HOLDLO;
      end
      S_LOW, S_HOLDLO, S_ERWAIT: if (timerZero) doEnd = 1'b1;
      S_WENT: if (timerZero) begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
      S_WEXIT: if (timerZero) begin
        ctl.vppClr = 1'b1;
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
    endcase

    if (doEnd) begin
      if (!frameEnd) begin
        doRise = 1'b1;
      end else if (opQ == OP_ERASE && !lastStep) begin
        stepNext     = step + STEP_W'(1);
        ctl.load     = 1'b1;
        ctl.loadWord = eraseFrame(step + STEP_W'(1));
        nextState    = S_START;
      end else begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
    end

    if (doRise) begin
      ctl.rise      = 1'b1;
      ctl.riseMode  = riseModeNow;
      ctl.timerLoad = 1'b1;
      ctl.tmrSel    = riseHold ? T_HHI : T_DIV;
      nextState     = riseHold ? S_HOLDHI : S_HIGH;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opQ   <= OP_CORE;
      step  <= '0;
    end else begin
      state <= nextState;
      opQ   <= opNext;
      step  <= stepNext;
    end
  end

endmodule

// File: rtl/serial_prog_seq.sv
module serial_prog_seq
  import sprog_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int HALF_DIV    = 4,
  parameter int ENTRY_CYC   = 100,
  parameter int EXIT_CYC    = 100,
  parameter int HOLD_HI_CYC = 1000,
  parameter int HOLD_LO_CYC = 50,
  parameter int ERASE_CYC   = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [2:0]  reqOp,
  input  logic [3:0]  reqCmd,
  input  logic [15:0] reqPayload,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdData,
  output logic        pgc,
  output logic        pgdOut,
  output logic        pgdOe,
  input  logic        pgdIn,
  output logic        vppEn
);

  ctl_t             ctl;
  logic [IDX_W-1:0] bitIdx;
  logic             timerZero;

  sprog_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqCmd    (reqCmd),
    .reqPayload(reqPayload),
    .bitIdx    (bitIdx),
    .timerZero (timerZero),
    .reqReady  (reqReady),
    .busy      (busy),
    .ctl       (ctl)
  );

  sprog_dp #(
    .TMR_W      (TMR_W),
    .HALF_DIV   (HALF_DIV),
    .ENTRY_CYC  (ENTRY_CYC),
    .EXIT_CYC   (EXIT_CYC),
    .HOLD_HI_CYC(HOLD_HI_CYC),
    .HOLD_LO_CYC(HOLD_LO_CYC),
    .ERASE_CYC  (ERASE_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .pgdIn    (pgdIn),
    .bitIdx   (bitIdx),
    .timerZero(timerZero),
    .pgc      (pgc),
    .pgdOut   (pgdOut),
    .pgdOe    (pgdOe),
    .vppEn    (vppEn),
    .done     (done),
    .rdData   (rdData)
  );

endmodule

// File: rtl/serial_prog_seq_chk.sv
module serial_prog_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic [2:0] reqOp,
  input logic       busy,
  input logic       done,
  input logic       pgc,
  input logic       pgdOut,
  input logic       pgdOe,
  input logic       vppEn
);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgc && $past(pgc)) |-> ($stable(pgdOut) && $stable(pgdOe)));

  // R5
  release_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pgdOe |-> busy);

  // R10
  clk_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgc |-> busy);

  // R2
  vpp_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vppEn) |-> $past(reqValid && reqReady && reqOp == 3'd0));

  // R8
  vpp_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vppEn) |-> done);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

endmodule

bind serial_prog_seq serial_prog_seq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqOp   (reqOp),
  .busy    (busy),
  .done    (done),
  .pgc     (pgc),
  .pgdOut  (pgdOut),
  .pgdOe   (pgdOe),
  .vppEn   (vppEn)
);

// File: tb/sim_serial_prog_seq.sv
`timescale 1ns/1ps
module sim_serial_prog_seq;

  localparam int DIV = 2;
  localparam int ENT = 6;
  localparam int EXT = 4;
  localparam int HHI = 7;
  localparam int HLO = 5;
  localparam int ERC = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = 3'd0;
  logic [3:0] reqCmd = 4'd0;
  logic [15:0] reqPayload = 16'd0;
  logic pgdIn = 1'b0;
  logic reqReady, busy, done, pgc, pgdOut, pgdOe, vppEn;
  logic [7:0] rdData;

  serial_prog_seq #(
    .TMR_W(16), .HALF_DIV(DIV), .ENTRY_CYC(ENT), .EXIT_CYC(EXT),
    .HOLD_HI_CYC(HHI), .HOLD_LO_CYC(HLO), .ERASE_CYC(ERC)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqCmd(reqCmd), .reqPayload(reqPayload),
    .busy(busy), .done(done), .rdData(rdData), .pgc(pgc),
    .pgdOut(pgdOut), .pgdOe(pgdOe), .pgdIn(pgdIn), .vppEn(vppEn)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // line monitor and target model, all on the falling system edge
  int nRise, nFall, hiLen, loLen, busyCyc, busyNoVpp, stabErr, doneBad, doneCnt, vppOff;
  int hiW [0:255];
  int loW [0:255];
  bit bitDat [0:255];
  bit bitOe  [0:255];
  bit tgtRead = 1'b0;
  logic [7:0] tgtByte = 8'd0;
  bit pgcPrev = 1'b0, datPrev = 1'b0, oePrev = 1'b1, busyPrev = 1'b0, donePrev = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (pgc && !pgcPrev) begin
        if (nRise < 256) loW[nRise] = loLen;
        if (tgtRead && nRise >= 12 && nRise < 20) pgdIn = tgtByte[nRise-12];
        else pgdIn = 1'b0;
        nRise++;
        hiLen = 1;
      end else if (pgc) hiLen++;
      if (!pgc && pgcPrev) begin
        if (nFall < 256) begin
          hiW[nFall] = hiLen;
          bitDat[nFall] = datPrev;
          bitOe[nFall] = oePrev;
        end
        nFall++;
        loLen = 1;
      end else if (!pgc) loLen++;
      if (pgc && pgcPrev && (pgdOut != datPrev || pgdOe != oePrev)) stabErr++;
      if (busy) busyCyc++;
      if (busy && !vppEn) busyNoVpp++;
      if (!vppEn) vppOff++;
      if (done) begin
        doneCnt++;
        if (!(busyPrev && !busy) || donePrev) doneBad++;
      end
      pgcPrev = pgc; datPrev = pgdOut; oePrev = pgdOe;
      busyPrev = busy; donePrev = done;
    end
  end

  task automatic clearMon();
    nRise = 0; nFall = 0; hiLen = 0; loLen = 0; busyCyc = 0; busyNoVpp = 0;
    doneCnt = 0;
  endtask

  bit busyAfterAccept;
  task automatic issue(input logic [2:0] op, input logic [3:0] cmd, input logic [15:0] pay);
    clearMon();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqOp = op; reqCmd = cmd; reqPayload = pay; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    busyAfterAccept = busy && !reqReady;
    while (!done) @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  // compares the recorded bits of frame f against {pay,cmd}; read selects R5 line rules
  function automatic int frameErrs(input int f, input logic [3:0] cmd, input logic [15:0] pay, input bit rd);
    logic [19:0] w;
    int e;
    w = {pay, cmd};
    e = 0;
    for (int n = 0; n < 20; n++) begin
      if (!rd || n < 4) begin
        if (bitDat[f*20+n] != w[n] || !bitOe[f*20+n]) e++;
      end else if (n < 12) begin
        if (bitDat[f*20+n] != 1'b0 || !bitOe[f*20+n]) e++;
      end else begin
        if (bitOe[f*20+n]) e++;
      end
    end
    return e;
  endfunction

  initial begin
    stabErr = 0; doneBad = 0; vppOff = 0;
    clearMon();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(pgc == 0 && pgdOut == 0 && pgdOe == 1, "R1 lines", {pgc, pgdOut, pgdOe}, 3'b001);
    check(vppEn == 0 && busy == 0 && done == 0 && reqReady == 1, "R1 status",
          {vppEn, busy, done, reqReady}, 4'b0001);

    // R2 mode entry
    issue(3'd0, 4'h0, 16'h0);
    check(busyCyc == ENT, "R2 entry wait", busyCyc, ENT);
    check(busyNoVpp == 0 && vppEn == 1, "R2 vpp high", busyNoVpp, 0);
    check(nRise == 0 && pgdOut == 0, "R2 no clocks", nRise, 0);
    check(busyAfterAccept, "R9 busy after accept", busyAfterAccept, 1);
    vppOff = 0;

    // R3 core frames, every command value
    for (int c = 0; c < 16; c++) begin
      logic [15:0] p;
      int wErr;
      p = 16'hA5C3 ^ (16'(c) * 16'h1357);
      issue(3'd1, 4'(c), p);
      wErr = 0;
      for (int n = 0; n < 20; n++) if (hiW[n] != DIV) wErr++;
      for (int n = 1; n < 20; n++) if (loW[n] != DIV) wErr++;
      check(nRise == 20 && frameErrs(0, 4'(c), p, 1'b0) == 0, "R3 bits", nRise, 20);
      check(wErr == 0, "R3 widths", wErr, 0);
      check(doneCnt == 1 && busyCyc == 1 + 20*2*DIV, "R9 busy span", busyCyc, 1 + 20*2*DIV);
    end

    // R5 read frames, every returned byte value
    tgtRead = 1'b1;
    for (int b = 0; b < 256; b++) begin
      tgtByte = 8'(b);
      issue(3'd2, 4'h9, 16'hFFFF);
      check(rdData == 8'(b), "R5 byte", rdData, b);
      check(nRise == 20 && frameErrs(0, 4'h9, 16'hFFFF, 1'b1) == 0, "R5 line use",
            frameErrs(0, 4'h9, 16'hFFFF, 1'b1), 0);
    end
    tgtRead = 1'b0;

    // R6 programming frames
    for (int k = 0; k < 3; k++) begin
      logic [15:0] p;
      int wErr;
      p = 16'h0F00 + 16'(k * 16'h3131);
      issue(3'd3, 4'h0, p);
      wErr = 0;
      for (int n = 0; n < 20; n++) if (hiW[n] != ((n == 3) ? HHI : DIV)) wErr++;
      for (int n = 1; n < 20; n++) if (loW[n] != ((n == 4) ? HLO : DIV)) wErr++;
      check(hiW[3] == HHI, "R6 hold high", hiW[3], HHI);
      check(loW[4] == HLO, "R6 hold low", loW[4], HLO);
      check(wErr == 0 && frameErrs(0, 4'h0, p, 1'b0) == 0, "R6 frame", wErr, 0);
    end

    // R7 bulk erase
    begin
      logic [3:0]  ec [0:11];
      logic [15:0] ep [0:11];
      int fe;
      ec = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hC, 4'h0, 4'h0, 4'hC, 4'h0, 4'h0};
      ep = '{16'h0E3C, 16'h6EF8, 16'h0E00, 16'h6EF7, 16'h0E05, 16'h6EF6,
             16'h0F0F, 16'h0E04, 16'h6EF6, 16'h8F8F, 16'h0000, 16'h0000};
      issue(3'd5, 4'h0, 16'h0);
      fe = 0;
      for (int f = 0; f < 12; f++) fe += frameErrs(f, ec[f], ep[f], 1'b0);
      check(nRise == 240, "R7 clock count", nRise, 240);
      check(fe == 0, "R7 frame contents", fe, 0);
      check(loW[11*20+4] == ERC + HLO, "R7 erase hold", loW[11*20+4], ERC + HLO);
      check(bitDat[11*20+3] == 0 && doneCnt == 1, "R7 data low", bitDat[11*20+3], 0);
    end

    // R10 vpp never dropped during frames
    check(vppOff == 0 && vppEn == 1, "R10 vpp kept", vppOff, 0);

    // R8 exit
    issue(3'd4, 4'h0, 16'h0);
    check(busyCyc == EXT, "R8 exit wait", busyCyc, EXT);
    check(busyNoVpp == 0, "R8 vpp held", busyNoVpp, 0);
    check(vppEn == 0 && pgc == 0 && pgdOut == 0, "R8 lines off", {vppEn, pgc, pgdOut}, 0);

    // R4 and R9 over the whole run
    check(stabErr == 0, "R4 data stable while clock high", stabErr, 0);
    check(doneBad == 0, "R9 done pulse shape", doneBad, 0);
    check(reqReady == 1 && busy == 0, "R9 ready when idle", {reqReady, busy}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule